// File: doc/BRIEF.md
# Wait-State Bus Cycle Sequencer

This block turns single requests from a processor core into read or write cycles on a multiplexed address/data bus. Each cycle runs through four fixed clock states. In the first state the address is driven and latched. In the second the read or write strobe goes active. In the third the device's readiness is checked. In the fourth the strobe is removed and the core is acknowledged. Memory and I/O cycles follow the same timing. A separate indicator on the bus tells the two apart.

The addressed device can stretch a cycle without limit. It does this by holding its ready line low. The ready line first passes through a two-flop synchroniser. Its synchronised value is examined only in the third state, and while it reads low that state repeats. The core therefore stalls until the device answers.

A core raises `core_req` with the address, write data, direction and memory/I/O selector held steady. It then waits for the one-clock `core_ack` pulse. After that pulse it must drop `core_req`. For a read, `core_rdata` is valid during the pulse.

The states are:
- **IDLE**: no cycle in progress.
- **T1**: address phase.
- **T2**: strobe phase.
- **T3**: ready check, repeated once for each wait state.
- **T4**: finish and acknowledge.

The transitions are:
- **accept**: IDLE→T1 when `core_req` is high.
- **advance**: T1→T2, then T2→T3.
- **wait**: T3→T3 while the synchronised ready is low.
- **release**: T3→T4 when the synchronised ready is high.
- **retire**: T4→IDLE.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, and in IDLE, `bus_ale`, `bus_rd`, `bus_wr`, `bus_ad_oe`, `bus_io` and `core_ack` are all low, and `bus_ad_o` is zero.
- R2: A request is taken only in IDLE. In the clock after it is seen, the sequencer is in T1: `bus_ale` is high for exactly that clock, `bus_ad_oe` is high and `bus_ad_o` carries the address.
- R3: In T2 and in every T3, a read holds `bus_rd` high and a write holds `bus_wr` high. The two strobes are never high together. On a read, `bus_ad_oe` is low from T2 until the end of the cycle.
- R4: `bus_ready` passes through two flip-flops and is looked at only in T3. While the synchronised value is low, T3 repeats, with no upper bound. The strobe therefore stays high for exactly 2 + N clocks, where N is the number of wait states. A device that raises `bus_ready` during the k-th clock of the cycle (T1 counts as clock 1) gives N = k − 1, or N = 0 when k is 1.
- R5: In T4 both strobes are low and `core_ack` is high for exactly one clock. The next clock is IDLE.
- R6: On a read, `bus_ad_i` is captured at the end of the T3 clock in which the synchronised ready is high. The captured value appears on `core_rdata` during the `core_ack` clock and holds afterwards.
- R7: On a write, `bus_ad_o` carries the write data with `bus_ad_oe` high from T2 through T4.
- R8: `bus_io` equals the request's I/O selector (1 = I/O, 0 = memory) from T1 through T4. Memory and I/O cycles have identical timing.
- R9: With no wait states, `core_ack` rises in the fourth clock after the request is accepted, counting T1 as the first.
- R10: The address, data, direction and selector are registered at acceptance. Changing the core inputs during a cycle has no effect on the bus lines of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_req | input | 1 | Core requests a bus cycle |
| core_write | input | 1 | 1 = write, 0 = read |
| core_io | input | 1 | 1 = I/O space, 0 = memory |
| core_addr | input | BUS_W | Cycle address |
| core_wdata | input | BUS_W | Write data |
| core_ack | output | 1 | One-clock completion pulse (T4) |
| core_rdata | output | BUS_W | Captured read data |
| bus_ad_o | output | BUS_W | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_o |
| bus_ad_i | input | BUS_W | Multiplexed data in |
| bus_ale | output | 1 | Address latch enable (T1) |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_io | output | 1 | I/O (1) versus memory (0) indicator |
| bus_ready | input | 1 | Asynchronous device ready |

## Verification
The hardest case to reach is a long stall: a cycle held in T3 for hundreds of clocks, with the two synchroniser stages making the exact count depend on when the device reacts. The bench device model raises ready in a chosen clock of the cycle, with counts of 0, 1, 2, 3, 5 and 300. It drives valid read data only in the final T3, so a capture in any other clock returns wrong data. A per-clock reference model predicts every bus line and counts the strobe width against the programmed wait count. During each cycle the bench also inverts the core inputs, to show that the registered copies are the ones on the bus.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_T4   = 3'd4
    } bcs_state_e;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/bcs_ready_sync.sv
module bcs_ready_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       core_req,
    input  logic       dir_wr,
    input  logic       ready_s,
    output bcs_state_e state,
    output logic       accept,
    output logic       ale,
    output logic       rd_strb,
    output logic       wr_strb,
    output logic       ad_oe,
    output logic       sel_data,
    output logic       io_act,
    output logic       capture,
    output logic       ack
);
    bcs_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (core_req) nxt = ST_T1;
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   if (ready_s) nxt = ST_T4;
            ST_T4:   nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        ale      = 1'b0;
        rd_strb  = 1'b0;
        wr_strb  = 1'b0;
        ad_oe    = 1'b0;
        sel_data = 1'b0;
        io_act   = 1'b0;
        capture  = 1'b0;
        ack      = 1'b0;
        unique case (state)
            ST_IDLE: accept = core_req;
            ST_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                io_act = 1'b1;
            end
            ST_T2: begin
                rd_strb  = !dir_wr;
                wr_strb  = dir_wr;
                ad_oe    = dir_wr;
                sel_data = 1'b1;
                io_act   = 1'b1;
            end
            ST_T3: begin
                rd_strb  = !dir_wr;
                wr_strb  = dir_wr;
                ad_oe    = dir_wr;
                sel_data = 1'b1;
                io_act   = 1'b1;
                capture  = ready_s && !dir_wr;
            end
            ST_T4: begin
                ad_oe    = dir_wr;
                sel_data = 1'b1;
                io_act   = 1'b1;
                ack      = 1'b1;
            end
            default: ;
        endcase
    end

    // R4
    wait_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T3 && !ready_s) |=> (state == ST_T3));

    // R5
    t4_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T4) |=> (state == ST_IDLE));

endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath #(
    parameter int unsigned BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             capture,
    input  logic             sel_data,
    input  logic             ad_oe,
    input  logic             io_act,
    input  logic             core_write,
    input  logic             core_io,
    input  logic [BUS_W-1:0] core_addr,
    input  logic [BUS_W-1:0] core_wdata,
    input  logic [BUS_W-1:0] bus_ad_i,
    output logic             dir_wr,
    output logic             bus_io,
    output logic [BUS_W-1:0] bus_ad_o,
    output logic [BUS_W-1:0] rdata
);
    logic [BUS_W-1:0] addr_q;
    logic [BUS_W-1:0] wdata_q;
    logic             wr_q;
    logic             io_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            io_q    <= 1'b0;
        end else if (accept) begin
            addr_q  <= core_addr;
            wdata_q <= core_wdata;
            wr_q    <= core_write;
            io_q    <= core_io;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata <= '0;
        else if (capture) rdata <= bus_ad_i;
    end

    assign dir_wr   = wr_q;
    assign bus_io   = io_act & io_q;
    assign bus_ad_o = ad_oe ? (sel_data ? wdata_q : addr_q) : '0;

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int unsigned BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_req,
    input  logic             core_write,
    input  logic             core_io,
    input  logic [BUS_W-1:0] core_addr,
    input  logic [BUS_W-1:0] core_wdata,
    output logic             core_ack,
    output logic [BUS_W-1:0] core_rdata,
    output logic [BUS_W-1:0] bus_ad_o,
    output logic             bus_ad_oe,
    input  logic [BUS_W-1:0] bus_ad_i,
    output logic             bus_ale,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic             bus_io,
    input  logic             bus_ready
);
    bcs_state_e state;
    logic ready_s, accept, sel_data, io_act, capture, dir_wr;

    bcs_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_ready),
        .sync_out (ready_s)
    );

    bcs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .core_req (core_req),
        .dir_wr   (dir_wr),
        .ready_s  (ready_s),
        .state    (state),
        .accept   (accept),
        .ale      (bus_ale),
        .rd_strb  (bus_rd),
        .wr_strb  (bus_wr),
        .ad_oe    (bus_ad_oe),
        .sel_data (sel_data),
        .io_act   (io_act),
        .capture  (capture),
        .ack      (core_ack)
    );

    bcs_datapath #(.BUS_W(BUS_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .sel_data   (sel_data),
        .ad_oe      (bus_ad_oe),
        .io_act     (io_act),
        .core_write (core_write),
        .core_io    (core_io),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .bus_ad_i   (bus_ad_i),
        .dir_wr     (dir_wr),
        .bus_io     (bus_io),
        .bus_ad_o   (bus_ad_o),
        .rdata      (core_rdata)
    );

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R2
    ale_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> ((bus_rd || bus_wr) && !bus_ale));

    // R5
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |=> !core_ack);

    // R7
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_ad_oe);

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |=> $stable(core_rdata));

endmodule

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_req = 1'b0, core_write = 1'b0, core_io = 1'b0;
    logic [W-1:0] core_addr = '0, core_wdata = '0, bus_ad_i = '0;
    logic bus_ready = 1'b0;
    logic core_ack, bus_ad_oe, bus_ale, bus_rd, bus_wr, bus_io;
    logic [W-1:0] core_rdata, bus_ad_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bus_cycle_seq #(.BUS_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_write(core_write), .core_io(core_io),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_ack(core_ack), .core_rdata(core_rdata),
        .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i),
        .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_io(bus_io), .bus_ready(bus_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // control vector order: {ale, rd, wr, oe, io, ack}
    function automatic logic [5:0] ctrl();
        return {bus_ale, bus_rd, bus_wr, bus_ad_oe, bus_io, core_ack};
    endfunction

    task automatic chk_idle(input string tag);
        chk({tag, " ctrl"}, 32'(ctrl()), 32'd0);
        chk({tag, " ad"}, 32'(bus_ad_o), 32'd0);
    endtask

    task automatic run_cycle(input logic wr, input logic io, input logic [W-1:0] a,
                             input logic [W-1:0] d, input logic [W-1:0] rv, input int waits);
        int total = 4 + waits;
        int strobe_n = 0;
        int ack_k = 0;
        logic [5:0] exp_c;
        logic [W-1:0] exp_ad;
        string tag;
        @(negedge clk);
        core_req = 1'b1; core_write = wr; core_io = io;
        core_addr = a; core_wdata = d; bus_ready = 1'b0; bus_ad_i = ~rv;
        #1 chk_idle("R1 accept clock");
        for (int k = 1; k <= total; k++) begin
            @(negedge clk);
            if (k == 2) begin
                core_addr = ~a; core_wdata = ~d; core_io = ~io; core_write = ~wr; // R10
            end
            bus_ready = (k >= 1 + waits);
            bus_ad_i  = (k >= 3 + waits && !wr) ? rv : ~rv;
            #1;
            if (bus_rd || bus_wr) strobe_n++;
            if (core_ack && ack_k == 0) ack_k = k;
            if (k == 1) begin
                exp_c = {1'b1, 1'b0, 1'b0, 1'b1, io, 1'b0}; exp_ad = a; tag = "R2 R8 T1";
            end else if (k == 2) begin
                exp_c = {1'b0, !wr, wr, wr, io, 1'b0}; exp_ad = wr ? d : '0; tag = "R3 R7 R8 R10 T2";
            end else if (k < total) begin
                exp_c = {1'b0, !wr, wr, wr, io, 1'b0}; exp_ad = wr ? d : '0; tag = "R4 R7 R8 R10 T3";
            end else begin
                exp_c = {1'b0, 1'b0, 1'b0, wr, io, 1'b1}; exp_ad = wr ? d : '0; tag = "R5 R7 R8 T4";
            end
            chk({tag, " ctrl"}, 32'(ctrl()), 32'(exp_c));
            chk({tag, " ad"}, 32'(bus_ad_o), 32'(exp_ad));
            if (k == total && !wr) chk("R6 rdata at ack", 32'(core_rdata), 32'(rv));
        end
        chk("R4 strobe clocks", 32'(strobe_n), 32'(waits + 2));
        chk("R9 ack clock", 32'(ack_k), 32'(total));
        @(negedge clk);
        core_req = 1'b0; bus_ready = 1'b0; bus_ad_i = '0;
        #1;
        chk_idle("R5 after T4");
        if (!wr) chk("R6 rdata held", 32'(core_rdata), 32'(rv));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 chk_idle("R1 in reset");
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1 chk_idle("R1 idle");
        end
        run_cycle(1'b0, 1'b0, 16'h1234, 16'h0000, 16'hA5C3, 0);   // R9 memory read
        run_cycle(1'b1, 1'b0, 16'h2040, 16'hBEEF, 16'h0000, 0);   // memory write
        run_cycle(1'b0, 1'b1, 16'h0060, 16'h0000, 16'h5A17, 1);   // R8 I/O read
        run_cycle(1'b1, 1'b1, 16'h0064, 16'hC0DE, 16'h0000, 3);   // I/O write
        run_cycle(1'b0, 1'b0, 16'h8000, 16'h0000, 16'h0F0F, 5);   // R6 memory read
        run_cycle(1'b0, 1'b1, 16'h03F8, 16'h0000, 16'h7E81, 300); // R4 long stall
        run_cycle(1'b1, 1'b0, 16'hFFFE, 16'h1357, 16'h0000, 2);
        run_cycle(1'b0, 1'b0, 16'h0000, 16'h0000, 16'hFFFF, 2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule